// File: doc/BRIEF.md
# Masked Interrupt Cause Aggregator

This block gathers level interrupts from up to 64 peripheral sources into one cause vector and raises a single CPU interrupt line whenever any cause that software has enabled is active. Every cause bit follows its source level, so a peripheral clears its cause by dropping its request. A 64-bit enable mask picks which causes reach the CPU line. Several positions in the vector are reserved: their inputs are dropped, and they always read as zero. Two of the unreserved groups, bits 24 to 27 and bits 56 to 59, are intended for per-byte summaries from general-purpose pin logic.

Software uses a 32-bit register port with separate read and write strobes and a 3-bit register select. Address 0 reads the low cause word and address 1 reads the high cause word. Address 2 is the low mask half and address 3 is the high mask half. Address 4 is the select-cause view. It returns the 32-bit cause half that holds enabled pending causes, and its top bits say which half was returned. The interrupt handler can therefore serve the common case with one read.

A small state register records which halves hold enabled pending causes. The states are PEND_NONE, PEND_LOW, PEND_HIGH and PEND_BOTH. On each clock the state moves to the class of the current masked cause vector, so any state can go to any other state. The CPU line is driven from this state and is high in every state except PEND_NONE.

Top module: `irq_cause_agg`

## Requirements
- R1: Each unreserved cause bit takes the level of its source input one clock after the input is sampled. Cause bits 31:0 read at address 0, and bits 63:32 read at address 1.
- R2: The reserved cause bits are 29 to 31, 35, 51 to 55 and 61 to 63. They read as zero whatever their inputs do.
- R3: Reset clears every cause bit, every mask bit, the read data and the CPU interrupt line.
- R4: A write to address 2 loads mask bits 31:0 and leaves mask bits 63:32 unchanged. A read of address 2 returns mask bits 31:0.
- R5: A write to address 3 loads mask bits 63:32 and leaves mask bits 31:0 unchanged. A read of address 3 returns mask bits 63:32.
- R6: The CPU interrupt output is a registered OR of (cause AND mask). It is high one clock after any enabled cause bit is set, and low one clock after none is set.
- R7: When no enabled cause is pending, or enabled causes are pending only in bits 31:0, a read of address 4 returns the low cause word unchanged.
- R8: When enabled causes are pending only in bits 63:32, a read of address 4 returns the high cause word with bit 30 set.
- R9: When enabled causes are pending in both halves, a read of address 4 returns the low cause word with bit 31 set.
- R10: Writes to addresses 0, 1, 4, 5, 6 and 7 change no state. Reads of addresses 5 to 7 return zero.
- R11: Read data appears on the clock edge that samples the read strobe, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Level interrupt requests, one per cause bit |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register select |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| cpu_irq_o | output | 1 | Summarized CPU interrupt |

## Verification
A source change reaches the cause registers one edge later and reaches the CPU line two edges later. A read returns data on the edge that samples its strobe, and a mask write takes effect on the edge that samples it. The bench waits two edges after every source change before it checks the interrupt line or reads a register. It samples one time unit after each edge and compares against a model of the source vector and the mask halves. Random source patterns and masks are mixed with directed cases for each select-cause class.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int CAUSE_W = 64;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 3;

    localparam logic [CAUSE_W-1:0] RSVD_MASK = 64'hE0F8_0008_E000_0000;

    localparam logic [ADDR_W-1:0] A_CAUSE_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CAUSE_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_SELECT   = 3'd4;

    localparam int FLAG_HIGH_BIT = 30;
    localparam int FLAG_BOTH_BIT = 31;

    typedef enum logic [1:0] {
        PEND_NONE = 2'b00,
        PEND_LOW  = 2'b01,
        PEND_HIGH = 2'b10,
        PEND_BOTH = 2'b11
    } pend_e;
endpackage

// File: rtl/irqagg_cause_store.sv
module irqagg_cause_store
    import irqagg_pkg::*;
#(
    parameter int                 WIDTH = CAUSE_W,
    parameter logic [WIDTH-1:0]   RSVD  = RSVD_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] cause_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (RSVD[b]) begin : g_rsvd
            assign cause_o[b] = 1'b0;
        end else begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= src_i[b];
            end
            assign cause_o[b] = bit_q;
        end
    end

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o & RSVD) == '0);

    assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cause_o == ($past(src_i) & ~RSVD));
endmodule

// File: rtl/irqagg_mask_regs.sv
module irqagg_mask_regs
    import irqagg_pkg::*;
#(
    parameter int HALF = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [HALF-1:0]   wdata_i,
    output logic [2*HALF-1:0] mask_o
);
    logic [HALF-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo_i) lo_q <= wdata_i;
            if (wr_hi_i) hi_q <= wdata_i;
        end
    end

    assign mask_o = {hi_q, lo_q};

    assert_hi_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !wr_hi_i) |=> $stable(hi_q));

    assert_lo_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !wr_lo_i) |=> $stable(lo_q));
endmodule

// File: rtl/irqagg_pend_fsm.sv
module irqagg_pend_fsm
    import irqagg_pkg::*;
#(
    parameter int WIDTH = CAUSE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] masked_i,
    output pend_e            class_o,
    output logic             irq_o
);
    localparam int HALF = WIDTH / 2;

    pend_e state_q, state_d;
    logic  lo_any, hi_any;

    assign lo_any = |masked_i[HALF-1:0];
    assign hi_any = |masked_i[WIDTH-1:HALF];

    always_comb begin
        unique case ({hi_any, lo_any})
            2'b00:   state_d = PEND_NONE;
            2'b01:   state_d = PEND_LOW;
            2'b10:   state_d = PEND_HIGH;
            default: state_d = PEND_BOTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PEND_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PEND_NONE: irq_o = 1'b0;
            PEND_LOW,
            PEND_HIGH,
            PEND_BOTH: irq_o = 1'b1;
            default:   irq_o = 1'b0;
        endcase
    end

    assign class_o = state_d;
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CAUSE_W-1:0] src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              cpu_irq_o
);
    localparam int HALF = CAUSE_W / 2;

    logic [CAUSE_W-1:0] cause, mask, masked;
    pend_e              sel_class;
    logic [WORD_W-1:0]  rd_d, rdata_q, sel_word;

    irqagg_cause_store #(.WIDTH(CAUSE_W), .RSVD(RSVD_MASK)) u_cause (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .cause_o(cause)
    );

    irqagg_mask_regs #(.HALF(HALF)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .wr_lo_i(bus_wr_i && bus_addr_i == A_MASK_LO),
        .wr_hi_i(bus_wr_i && bus_addr_i == A_MASK_HI),
        .wdata_i(bus_wdata_i), .mask_o(mask)
    );

    assign masked = cause & mask;

    irqagg_pend_fsm #(.WIDTH(CAUSE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .masked_i(masked),
        .class_o(sel_class), .irq_o(cpu_irq_o)
    );

    always_comb begin
        unique case (sel_class)
            PEND_HIGH: sel_word = cause[CAUSE_W-1:HALF] | (WORD_W'(1) << FLAG_HIGH_BIT);
            PEND_BOTH: sel_word = cause[HALF-1:0] | (WORD_W'(1) << FLAG_BOTH_BIT);
            default:   sel_word = cause[HALF-1:0];
        endcase
    end

    always_comb begin
        unique case (bus_addr_i)
            A_CAUSE_LO: rd_d = cause[HALF-1:0];
            A_CAUSE_HI: rd_d = cause[CAUSE_W-1:HALF];
            A_MASK_LO:  rd_d = mask[HALF-1:0];
            A_MASK_HI:  rd_d = mask[CAUSE_W-1:HALF];
            A_SELECT:   rd_d = sel_word;
            default:    rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= rd_d;
    end

    assign bus_rdata_o = rdata_q;

    assert_irq_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cpu_irq_o == |($past(cause) & $past(mask)));

    assert_sel_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == A_SELECT && masked[HALF-1:0] == '0
         && masked[CAUSE_W-1:HALF] != '0) |=> bus_rdata_o[FLAG_HIGH_BIT]);

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

// File: tb/irq_cause_agg_test.sv
module irq_cause_agg_test;
    import irqagg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_mask = '0;

    always #2 clk = ~clk;

    irq_cause_agg uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cpu_irq_o(irq)
    );

    localparam logic [63:0] TB_RSVD = 64'hE0F8_0008_E000_0000;

    function automatic logic [63:0] exp_cause(logic [63:0] s);
        return s & ~TB_RSVD;
    endfunction

    function automatic logic [31:0] exp_select(logic [63:0] c, logic [63:0] m);
        logic [31:0] lo_m = c[31:0] & m[31:0];
        logic [31:0] hi_m = c[63:32] & m[63:32];
        if (hi_m != 0 && lo_m == 0) return c[63:32] | 32'h4000_0000;
        if (hi_m != 0 && lo_m != 0) return c[31:0] | 32'h8000_0000;
        return c[31:0];
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0;
        if (a == A_MASK_LO) m_mask[31:0] = d;
        if (a == A_MASK_HI) m_mask[63:32] = d;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        rd = 1'b1; addr = a;
        tick();
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic apply_src(logic [63:0] s);
        src = s;
        tick();
        tick();
    endtask

    task automatic full_check(string tag);
        logic [31:0] v;
        logic [63:0] c = exp_cause(src);
        rd_reg(A_CAUSE_LO, v); check({tag, " R1 cause_lo"}, 64'(v), 64'(c[31:0]));
        rd_reg(A_CAUSE_HI, v); check({tag, " R1 R2 cause_hi"}, 64'(v), 64'(c[63:32]));
        rd_reg(A_MASK_LO, v);  check({tag, " R4 mask_lo"}, 64'(v), 64'(m_mask[31:0]));
        rd_reg(A_MASK_HI, v);  check({tag, " R5 mask_hi"}, 64'(v), 64'(m_mask[63:32]));
        rd_reg(A_SELECT, v);   check({tag, " R7 R8 R9 select"}, 64'(v), 64'(exp_select(c, m_mask)));
        check({tag, " R6 irq"}, 64'(irq), 64'(|(c & m_mask)));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [63:0] c;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        // R3: reset state
        check("R3 rdata", 64'(rdata), 64'd0);
        check("R3 irq", 64'(irq), 64'd0);
        src = '1;
        tick();
        rst_n = 1'b1;
        tick();
        rd_reg(A_MASK_LO, v); check("R3 mask_lo", 64'(v), 64'd0);
        rd_reg(A_MASK_HI, v); check("R3 mask_hi", 64'(v), 64'd0);
        // R2: all sources high, reserved bits must read zero
        rd_reg(A_CAUSE_LO, v); check("R2 lo reserved", 64'(v), 64'h1FFF_FFFF);
        rd_reg(A_CAUSE_HI, v); check("R2 hi reserved", 64'(v), 64'h1F07_FFF7);
        check("R6 irq masked off", 64'(irq), 64'd0);

        // R7: no pending masked, low returned as is
        apply_src(64'h0000_0100_0000_0040);
        full_check("none");
        // R7 low only
        wr_reg(A_MASK_LO, 32'h0000_0040);
        tick();
        full_check("low");
        // R8 high only
        wr_reg(A_MASK_LO, 32'h0);
        wr_reg(A_MASK_HI, 32'h0000_0100);
        tick();
        full_check("high");
        // R9 both
        wr_reg(A_MASK_LO, 32'hFFFF_FFFF);
        tick();
        full_check("both");
        // R4 and R5: half writes keep other half
        wr_reg(A_MASK_HI, 32'h1234_5678);
        rd_reg(A_MASK_LO, v); check("R5 low kept", 64'(v), 64'hFFFF_FFFF);
        wr_reg(A_MASK_LO, 32'h0BAD_F00D);
        rd_reg(A_MASK_HI, v); check("R4 high kept", 64'(v), 64'h1234_5678);

        // R10: writes to other addresses have no effect
        wr_reg(A_CAUSE_LO, 32'hFFFF_FFFF);
        wr_reg(A_CAUSE_HI, 32'hFFFF_FFFF);
        wr_reg(A_SELECT, 32'hFFFF_FFFF);
        wr_reg(3'd5, 32'h0);
        wr_reg(3'd6, 32'h0);
        wr_reg(3'd7, 32'h0);
        full_check("R10 ignored writes");
        rd_reg(3'd6, v); check("R10 unmapped read", 64'(v), 64'd0);

        // R11: rdata holds without read strobe
        rd_reg(A_MASK_HI, v);
        apply_src('0);
        wr_reg(A_MASK_HI, 32'h0);
        tick();
        check("R11 hold", 64'(rdata), 64'h1234_5678);
        check("R6 irq low after clear", 64'(irq), 64'd0);

        // R6 timing: irq one cycle after cause
        wr_reg(A_MASK_LO, 32'h1);
        src = 64'h1;
        tick();
        check("R6 not yet", 64'(irq), 64'd0);
        tick();
        check("R6 raised", 64'(irq), 64'd1);
        src = 64'h0;
        tick(); tick();
        check("R1 R6 dropped", 64'(irq), 64'd0);

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [63:0] s;
            s = {$urandom(), $urandom()};
            if (i % 4 == 1) s[31:0] = '0;
            if (i % 4 == 2) s[63:32] = '0;
            if (i % 5 == 0) wr_reg(A_MASK_LO, $urandom());
            if (i % 3 == 0) wr_reg(A_MASK_HI, $urandom());
            apply_src(s);
            full_check("random");
        end

        c = exp_cause(src);
        if (c == 64'hx) check("unused", 64'd0, 64'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule